// File: doc/BRIEF.md
# Counter Block Incrementer for Counter-Style Cipher Modes

This block holds the 128-bit counter block that feeds a block cipher running in a counter-style mode, and advances it once for each block consumed. A load strobe copies the initial vector into the register when a new context starts. Each step then adds one to a selected low-order field and wraps inside that field. The bits above the field act as a fixed nonce and are never changed by a step.

The mode input picks the field. General counter mode uses a 2-bit width code that chooses 32, 64 or 128 bits. Integer counter mode always counts on the low 16 bits. Galois counter mode always counts on the low 32 bits and has a block budget. Once the budget of blocks has been used since the last load, a further step raises a sticky limit flag and leaves the counter frozen until the next load. A fourth mode code leaves the counter idle. The cipher itself and the keystream XOR sit outside this block.

Top module: `ctr_block_step`

## Requirements
- R1: While reset is asserted, and after it is released, the counter output is all zeros and the limit flag is low.
- R2: A load puts the load value on the counter output from the next cycle. It clears the limit flag and the block budget, and it takes priority over a step in the same cycle.
- R3: In general counter mode (mode code 0), width code 0 increments the low 32 bits, code 1 the low 64 bits and code 2 all 128 bits, each modulo 2^N.
- R4: In general counter mode, width code 3 behaves like code 2: the whole 128-bit block increments.
- R5: In integer counter mode (mode code 1), a step increments bits [15:0] modulo 2^16 and leaves bits [127:16] unchanged, whatever the width code is.
- R6: In Galois mode (mode code 2), a step increments bits [31:0] modulo 2^32 and leaves bits [127:32] unchanged.
- R7: A wrap of the selected field never carries into the bits above it.
- R8: In Galois mode, after BLK_LIMIT steps have been taken since the last load (default 2^32 − 2), a further step sets the limit flag and does not change the counter. While the flag is set, steps leave the counter unchanged, and only a load clears the flag.
- R9: With mode code 3, a step leaves the counter unchanged and never sets the flag.
- R10: Without a step or a load, the counter holds its value.
- R11: In modes 0 and 1 the budget never raises the flag, however many steps are taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start a new context from load_val |
| load_val | input | 128 | Initial counter block |
| mode_sel | input | 2 | 0 general, 1 integer (16-bit), 2 Galois (32-bit), 3 idle |
| width_sel | input | 2 | General-mode field: 0=32, 1=64, 2=128, 3=128 bits |
| step | input | 1 | Advance by one block |
| ctr_q | output | 128 | Current counter block |
| limit_flag | output | 1 | Galois block budget exceeded (sticky) |

## Verification
The bench loads values whose selected field is all ones and then steps. A wrap that carried one position too far would flip bit N, and an increment applied to the wrong field would leave the low ones in place. Width code 3 and integer mode are tried with neighbouring bits set, which exposes a decoder that mixes up codes. The budget is shrunk so the bench can walk up to it: a design that is off by one would flag a step early or late, and one that keeps counting under the flag would change the counter. General mode is stepped past the same budget to show that the flag stays low outside Galois mode.

// File: rtl/ctr_step_pkg.sv
package ctr_step_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned N_FIELDS = 4;

  typedef enum logic [1:0] {
    MODE_CTR   = 2'd0,
    MODE_INT16 = 2'd1,
    MODE_GAL   = 2'd2,
    MODE_IDLE  = 2'd3
  } ctr_mode_e;

  // field index: 0 -> 16 bits, 1 -> 32, 2 -> 64, 3 -> whole block
  function automatic int unsigned field_bits(input logic [1:0] idx);
    case (idx)
      2'd0:    return 16;
      2'd1:    return 32;
      2'd2:    return 64;
      default: return BLK_W;
    endcase
  endfunction

  function automatic logic [BLK_W-1:0] field_mask(input logic [1:0] idx);
    logic [BLK_W-1:0] ones;
    ones = '1;
    return ones >> (BLK_W - field_bits(idx));
  endfunction
endpackage

// File: rtl/ctr_field_dec.sv
module ctr_field_dec
  import ctr_step_pkg::*;
(
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       width_sel,
  output logic [1:0]       fidx,
  output logic [BLK_W-1:0] fmask,
  output logic             live
);
  always_comb begin
    live = 1'b1;
    unique case (ctr_mode_e'(mode_sel))
      MODE_INT16: fidx = 2'd0;
      MODE_GAL:   fidx = 2'd1;
      MODE_CTR: begin
        case (width_sel)
          2'd0:    fidx = 2'd1;
          2'd1:    fidx = 2'd2;
          default: fidx = 2'd3;   // codes 2 and 3 both span the block
        endcase
      end
      default: begin
        fidx = 2'd1;
        live = 1'b0;
      end
    endcase
    fmask = field_mask(fidx);
  end
endmodule

// File: rtl/ctr_field_inc.sv
module ctr_field_inc
  import ctr_step_pkg::*;
(
  input  logic [BLK_W-1:0] cur,
  input  logic [1:0]       fidx,
  output logic [BLK_W-1:0] nxt
);
  logic [BLK_W-1:0] cand [N_FIELDS];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    localparam int unsigned FW = field_bits(2'(g));
    if (FW >= BLK_W) begin : g_full
      assign cand[g] = cur + 1'b1;
    end else begin : g_part
      logic [FW-1:0] low_inc;
      assign low_inc = cur[FW-1:0] + 1'b1;
      assign cand[g] = {cur[BLK_W-1:FW], low_inc};
    end
  end

  assign nxt = cand[fidx];
endmodule

// File: rtl/ctr_blk_budget.sv
module ctr_blk_budget #(
  parameter longint unsigned BLK_LIMIT = 64'd4294967294,
  localparam int unsigned CNT_W = $clog2(BLK_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic trip,
  output logic spent,
  output logic flag
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(BLK_LIMIT);
  logic [CNT_W-1:0] used;

  assign spent = (used == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      used <= '0;
      flag <= 1'b0;
    end else begin
      if (adv && !spent) used <= used + 1'b1;
      if (trip) flag <= 1'b1;
    end
  end

  a_r8_flag_needs_spent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(spent));
endmodule

// File: rtl/ctr_block_step.sv
module ctr_block_step
  import ctr_step_pkg::*;
#(
  parameter longint unsigned BLK_LIMIT = 64'd4294967294
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [127:0] load_val,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   width_sel,
  input  logic         step,
  output logic [127:0] ctr_q,
  output logic         limit_flag
);
  logic [1:0]       fidx;
  logic [BLK_W-1:0] fmask;
  logic [BLK_W-1:0] ctr_nxt;
  logic             live, spent, is_gal;
  logic             step_req, limit_hit, step_take, trip;

  ctr_field_dec u_dec (
    .mode_sel (mode_sel),
    .width_sel(width_sel),
    .fidx     (fidx),
    .fmask    (fmask),
    .live     (live)
  );

  ctr_field_inc u_inc (
    .cur (ctr_q),
    .fidx(fidx),
    .nxt (ctr_nxt)
  );

  assign is_gal    = (mode_sel == MODE_GAL);
  assign step_req  = step && !load && live;
  assign limit_hit = limit_flag || (is_gal && spent);
  assign step_take = step_req && !limit_hit;
  assign trip      = step_req && is_gal && spent && !limit_flag;

  ctr_blk_budget #(.BLK_LIMIT(BLK_LIMIT)) u_bud (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (load),
    .adv  (step_take),
    .trip (trip),
    .spent(spent),
    .flag (limit_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctr_q <= '0;
    else if (load)      ctr_q <= load_val;
    else if (step_take) ctr_q <= ctr_nxt;
  end

  a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ctr_q == $past(load_val)) && !limit_flag);
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step_take |=> ((ctr_q ^ $past(ctr_q)) & ~$past(fmask)) == '0);
  a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_take |=> ctr_q != $past(ctr_q));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_flag && !load) |=> $stable(ctr_q) && limit_flag);
  a_r11_gal_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_flag) |-> $past(mode_sel) == MODE_GAL);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_sel == MODE_IDLE) |=> $stable(ctr_q));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ctr_q));
endmodule

// File: tb/sim_ctr_block_step.sv
module sim_ctr_block_step;
  localparam int LIM = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, step = 1'b0;
  logic [127:0] load_val = '0;
  logic [1:0] mode_sel = 2'd0, width_sel = 2'd0;
  logic [127:0] ctr_q;
  logic limit_flag;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] ctr;
    logic         flg;
    int           due;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [127:0] m_ctr = '0;
  logic         m_flg = 1'b0;
  int           m_used = 0;

  ctr_block_step #(.BLK_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .mode_sel(mode_sel), .width_sel(width_sel), .step(step),
    .ctr_q(ctr_q), .limit_flag(limit_flag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] bump(input logic [127:0] v, input int n);
    case (n)
      16:      return {v[127:16], v[15:0] + 16'd1};
      32:      return {v[127:32], v[31:0] + 32'd1};
      64:      return {v[127:64], v[63:0] + 64'd1};
      default: return v + 128'd1;
    endcase
  endfunction

  function automatic int width_of(input logic [1:0] m, input logic [1:0] w);
    if (m == 2'd1) return 16;
    if (m == 2'd2) return 32;
    return (w == 2'd0) ? 32 : (w == 2'd1) ? 64 : 128;
  endfunction

  task automatic op(input logic ld, input logic [127:0] v, input logic [1:0] m,
                    input logic [1:0] w, input logic st, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    load = ld; load_val = v; mode_sel = m; width_sel = w; step = st;
    if (ld) begin
      m_ctr = v; m_flg = 1'b0; m_used = 0;
    end else if (st && m != 2'd3 && !m_flg) begin
      if (m == 2'd2 && m_used == LIM) m_flg = 1'b1;
      else begin
        m_ctr = bump(m_ctr, width_of(m, w));
        if (m_used < LIM) m_used++;
      end
    end
    e.ctr = m_ctr; e.flg = m_flg; e.due = cyc + 1; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares every queued item in the cycle its result is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ctr_q !== e.ctr || limit_flag !== e.flg) begin
        errors++;
        $display("FAIL %s: ctr=%h flag=%b expected ctr=%h flag=%b",
                 e.tag, ctr_q, limit_flag, e.ctr, e.flg);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ctr_q !== '0 || limit_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1: ctr=%h flag=%b expected 0/0", ctr_q, limit_flag);
    end
    @(negedge clk) rst_n = 1'b1;
    op(0, '0, 0, 0, 0, "R1 after release");

    // R3 / R7: 32-bit field wraps, bit 32 untouched
    op(1, 128'h1234_5678_9ABC_DEF0_0000_0000_FFFF_FFFF, 0, 0, 0, "R2 load");
    op(0, '0, 0, 0, 1, "R3 R7 w32 wrap");
    op(0, '0, 0, 0, 1, "R3 w32 step");
    // R3: 64-bit field
    op(1, 128'hAAAA_0000_5555_0001_FFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R2 load");
    op(0, '0, 0, 1, 1, "R3 R7 w64 wrap");
    op(0, '0, 0, 1, 1, "R3 w64 step");
    // R3: 128-bit field, R4: code 3
    op(1, '1, 0, 0, 0, "R2 load");
    op(0, '0, 0, 2, 1, "R3 w128 wrap");
    op(1, 128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R2 load");
    op(0, '0, 0, 3, 1, "R4 code3 carries past 64");
    op(0, '0, 0, 3, 1, "R4 code3 step");
    // R5: integer mode ignores width code
    op(1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000_FFFF, 1, 2, 0, "R2 load");
    op(0, '0, 1, 2, 1, "R5 r7 wrap16");
    op(0, '0, 1, 3, 1, "R5 step16");
    // R6: Galois 32-bit field
    op(1, 128'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0E_FFFF_FFFF, 2, 0, 0, "R2 load");
    op(0, '0, 2, 3, 1, "R6 wrap32");
    // R10: idle hold
    op(0, '0, 2, 0, 0, "R10 hold");
    op(0, '0, 0, 2, 0, "R10 hold");
    // R9: idle mode
    op(0, '0, 3, 0, 1, "R9 idle step");
    op(0, '0, 3, 2, 1, "R9 idle step");
    // R2: load beats step
    op(1, 128'h00FF, 0, 0, 1, "R2 load over step");
    op(0, '0, 0, 0, 0, "R2 hold after load");

    // R8: Galois budget
    op(1, 128'h5A5A_0000_0000_0000_0000_0000_FFFF_FFFD, 2, 0, 0, "R2 load");
    for (int i = 0; i < LIM; i++) op(0, '0, 2, 0, 1, "R8 within budget");
    op(0, '0, 2, 0, 1, "R8 flag on overrun");
    op(0, '0, 2, 0, 1, "R8 frozen");
    op(0, '0, 0, 0, 1, "R8 frozen other mode");
    op(1, 128'h77, 2, 0, 0, "R2 R8 load clears");
    op(0, '0, 2, 0, 1, "R8 step after clear");

    // R11: general and integer modes never flag
    op(1, 128'h10, 0, 0, 0, "R2 load");
    for (int i = 0; i < LIM + 3; i++) op(0, '0, 0, 0, 1, "R11 ctr past budget");
    for (int i = 0; i < 3; i++) op(0, '0, 1, 0, 1, "R11 int past budget");
    op(0, '0, 2, 0, 1, "R8 gal after spent budget");

    op(0, '0, 0, 0, 0, "R10 final hold");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: left=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule